// File: doc/BRIEF.md
# Eight-Bit Programmable Pulse Generator

This block produces a square wave on one output pin. The wave has a programmable period and a programmable duty ratio. A single 8-bit up counter advances on each clock cycle in which the tick enable is high. Two compare values are checked against that counter. The edge value marks where the pin switches from its inactive level to its active level inside each period. The end value marks the last count of the period: on that tick the counter clears and the pin switches back. Each match raises its own one-cycle interrupt pulse. A polarity input selects whether the active level is high or low. The companion counter that would normally share this hardware is not used in this mode, so the block contains only one counter.

The sequencing is a three-state machine. `PS_IDLE` holds the counter at zero and the pin at its inactive level. `PS_LEAD` is the inactive part of a period, and `PS_TRAIL` is the active part. The transitions are as follows:

- start: `PS_IDLE` to `PS_LEAD` when run is high.
- edge: `PS_LEAD` to `PS_TRAIL` on a tick that matches the edge value.
- wrap: `PS_TRAIL` to `PS_LEAD` on a tick that matches the end value.
- lone wrap: `PS_LEAD` to `PS_TRAIL` on an end-value tick when the edge value cannot be reached.
- stop: any state to `PS_IDLE` when run is low.

Each match flips the pin. When the edge value is not below the end value, only the end match occurs, so the pin flips once per period.

Top module: `ppg8`

## Requirements
- R1: While run is low, the pin holds its inactive level and both interrupt outputs stay 0, even when ticks arrive. The block enters this idle condition at the first clock edge after run falls.
- R2: While running, the counter advances by one on each tick. It clears to zero on the tick taken at the end value P, so end-value interrupts are exactly P+1 ticks apart.
- R3: When the edge value D is below P, a tick at count D switches the pin to its active level. The duty interrupt is high for the one clock cycle that follows that tick edge.
- R4: A tick at count P flips the pin and clears the counter. The period interrupt is high for the one clock cycle that follows that tick edge.
- R5: With the polarity input at 1, the active level is 1 and the inactive level is 0. With the polarity input at 0, the active level is 0 and the inactive level is 1.
- R6: When D < P, each full period has D+1 ticks at the inactive level and P-D ticks at the active level.
- R7: When D >= P, the duty interrupt never fires and the pin flips only at count P. Each level then lasts P+1 ticks.
- R8: In a clock cycle without a tick, the counter, the pin and the state do not change, and no interrupt is raised.
- R9: One clock edge after run rises, counting starts from zero with the pin at its inactive level.
- R10: The two interrupt outputs are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one counter step per high cycle |
| run | input | 1 | Starts (1) or stops (0) the generator |
| pol_hi | input | 1 | 1: active-high pulse, 0: active-low pulse |
| edge_val | input | 8 | Count at which the pin goes active |
| end_val | input | 8 | Last count of the period |
| pulse_out | output | 1 | Generated square wave |
| irq_edge | output | 1 | One-cycle pulse after an edge-value match |
| irq_end | output | 1 | One-cycle pulse after an end-value match |

## Verification
The checker assumes that both compare values and the polarity change only while run is low. Under that assumption the counter can never pass the end value while the block is running. It also assumes that tick is held low during reset.

The bench keeps to these assumptions. Each case loads new compare values and a new polarity while the block is idle. Each case then holds those inputs fixed until run is lowered again. Ticks arrive with random gaps, and every gap is also used to check that nothing moves between ticks.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_LEAD  = 2'd1,
        PS_TRAIL = 2'd2
    } ppg_state_e;
endpackage

// File: rtl/ppg_counter.sv
module ppg_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/ppg_match.sv
module ppg_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] edge_val,
    input  logic [W-1:0] end_val,
    output logic         hit_edge,
    output logic         hit_end
);
    // The end match wins when both compare values are equal.
    always_comb begin
        hit_end  = (cnt == end_val);
        hit_edge = (cnt == edge_val) && !hit_end;
    end
endmodule

// File: rtl/ppg_fsm.sv
module ppg_fsm
    import ppg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic hit_edge,
    input  logic hit_end,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic active,
    output logic irq_edge,
    output logic irq_end
);
    ppg_state_e state_q, state_d;
    logic       step;

    assign step = run && tick && (state_q != PS_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: begin
                if (run)
                    state_d = PS_LEAD;
            end
            PS_LEAD: begin
                if (!run)
                    state_d = PS_IDLE;
                else if (step && (hit_edge || hit_end))
                    state_d = PS_TRAIL;
            end
            PS_TRAIL: begin
                if (!run)
                    state_d = PS_IDLE;
                else if (step && (hit_edge || hit_end))
                    state_d = PS_LEAD;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        cnt_clr = (state_q == PS_IDLE) || !run || (step && hit_end);
        cnt_inc = step && !hit_end;
        active  = (state_q == PS_TRAIL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_edge <= 1'b0;
            irq_end  <= 1'b0;
        end else begin
            irq_edge <= step && hit_edge;
            irq_end  <= step && hit_end;
        end
    end
endmodule

// File: rtl/ppg8.sv
module ppg8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         pol_hi,
    input  logic [W-1:0] edge_val,
    input  logic [W-1:0] end_val,
    output logic         pulse_out,
    output logic         irq_edge,
    output logic         irq_end
);
    logic [W-1:0] cnt_q;
    logic         cnt_clr, cnt_inc;
    logic         hit_edge, hit_end;
    logic         act;

    ppg_counter #(.W(W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt_q)
    );

    ppg_match #(.W(W)) u_cmp (
        .cnt     (cnt_q),
        .edge_val(edge_val),
        .end_val (end_val),
        .hit_edge(hit_edge),
        .hit_end (hit_end)
    );

    ppg_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .hit_edge(hit_edge),
        .hit_end (hit_end),
        .cnt_clr (cnt_clr),
        .cnt_inc (cnt_inc),
        .active  (act),
        .irq_edge(irq_edge),
        .irq_end (irq_end)
    );

    assign pulse_out = pol_hi ? act : !act;
endmodule

// File: rtl/ppg8_chk.sv
module ppg8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         tick,
    input logic [W-1:0] end_val,
    input logic [W-1:0] cnt,
    input logic         active,
    input logic         irq_edge,
    input logic         irq_end
);
    p_irq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_edge && irq_end));

    p_irq_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_edge || irq_end) |-> $past(tick));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(tick)) |-> ($stable(active) && $stable(cnt)));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!active && cnt == '0 && !irq_edge && !irq_end));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= end_val));

    p_edge_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_edge |-> active);

    p_end_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_end && run) |-> (cnt == '0));
endmodule

bind ppg8 ppg8_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .end_val (end_val),
    .cnt     (cnt_q),
    .active  (act),
    .irq_edge(irq_edge),
    .irq_end (irq_end)
);

// File: tb/tb_ppg8.sv
module tb_ppg8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       run = 1'b0;
    logic       pol_hi = 1'b1;
    logic [7:0] edge_val = 8'd0;
    logic [7:0] end_val = 8'd0;
    logic       pulse_out, irq_edge, irq_end;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ppg8 dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (run),
        .pol_hi   (pol_hi),
        .edge_val (edge_val),
        .end_val  (end_val),
        .pulse_out(pulse_out),
        .irq_edge (irq_edge),
        .irq_end  (irq_end)
    );

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // Level after tick j (1-based), counted from the start of the run.
    function automatic bit exp_active(int j, int d, int p);
        int r;
        r = (j - 1) % (p + 1);
        if (d < p) return (r >= d) && (r < p);
        return ((j / (p + 1)) % 2) == 1;
    endfunction

    function automatic int exp_len(bit is_active, int d, int p);
        if (d >= p) return p + 1;
        return is_active ? (p - d) : (d + 1);
    endfunction

    task automatic run_case(input int d, input int p, input bit pol, input int gap_max);
        int  nticks;
        int  last_end;
        bit  cur;
        int  len;
        bit  first;
        nticks   = 3 * (p + 1) + 2;
        last_end = 0;
        first    = 1'b1;
        len      = 0;
        cur      = 1'b0;
        @(negedge clk);
        edge_val = 8'(d);
        end_val  = 8'(p);
        pol_hi   = pol;
        run      = 1'b1;
        @(negedge clk);
        chk(pulse_out == !pol, "R9/R5 start level", pulse_out, !pol);
        for (int j = 1; j <= nticks; j++) begin
            int  r;
            bit  lvl_exp;
            bit  act_now;
            int  gap;
            r = (j - 1) % (p + 1);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            lvl_exp = exp_active(j, d, p) ? pol : !pol;
            chk(pulse_out == lvl_exp, (d < p) ? "R3 level" : "R7 level", pulse_out, lvl_exp);
            chk(irq_edge == ((d < p) && (r == d)), (d < p) ? "R3 irq_edge" : "R7 irq_edge",
                irq_edge, (d < p) && (r == d));
            chk(irq_end == (r == p), "R4 irq_end", irq_end, r == p);
            chk(!(irq_edge && irq_end), "R10 both irqs", 1, 0);
            if (irq_end) begin
                if (last_end != 0)
                    chk(j - last_end == p + 1, "R2 end spacing", j - last_end, p + 1);
                last_end = j;
            end
            act_now = (pulse_out == pol);
            if (j == 1) begin
                cur = act_now;
                len = 1;
            end else if (act_now == cur) begin
                len++;
            end else begin
                if (!first)
                    chk(len == exp_len(cur, d, p), cur ? "R6 active ticks" : "R6 inactive ticks",
                        len, exp_len(cur, d, p));
                first = 1'b0;
                cur   = act_now;
                len   = 1;
            end
            gap = int'($urandom_range(gap_max, 0));
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(pulse_out == lvl_exp && !irq_edge && !irq_end, "R8 no tick hold",
                    {irq_edge, irq_end, pulse_out}, {2'b00, lvl_exp});
            end
        end
        run = 1'b0;
        @(negedge clk);
        chk(pulse_out == !pol && !irq_edge && !irq_end, "R1 stop",
            {irq_edge, irq_end, pulse_out}, {2'b00, !pol});
        tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        chk(pulse_out == !pol && !irq_edge && !irq_end, "R1 ticks while idle",
            {irq_edge, irq_end, pulse_out}, {2'b00, !pol});
    endtask

    initial begin
        void'($urandom(32'd7715));
        repeat (3) @(negedge clk);
        chk(pulse_out == 1'b0 && !irq_edge && !irq_end, "R1 reset",
            {irq_edge, irq_end, pulse_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(3, 9, 1'b1, 2);
        run_case(3, 9, 1'b0, 0);
        run_case(0, 1, 1'b1, 1);
        run_case(0, 0, 1'b1, 1);
        run_case(4, 5, 1'b0, 2);
        run_case(7, 7, 1'b1, 1);
        run_case(20, 10, 1'b0, 1);
        run_case(254, 255, 1'b1, 0);
        run_case(0, 255, 1'b0, 0);
        for (int k = 0; k < 8; k++) begin
            int p;
            int d;
            p = int'($urandom_range(40, 1));
            d = int'($urandom_range(p + 3, 0));
            run_case(d, p, 1'($urandom_range(1, 0)), 2);
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule